// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental quadrature encoder into a position count. Each phase is passed through a two-flop synchroniser and a digital glitch filter. A selectable counting mode picks which phase edges produce a count step. The direction of each step comes from the level of the opposite phase. The count wraps inside a range from 0 to a programmable reload value, so a single revolution or any other modulus can be mapped directly onto the counter.

Two polarity controls invert either phase after the filter, which reverses the counting direction without any change to the wiring. A count enable freezes the position. Edges that arrive while the count is frozen are discarded, not deferred. A direction flag reports whether the last counted step went down or up.

Top module: `quad_enc_counter`

## Requirements
- R1: After reset, count_o is 0 and dir_o is 0.
- R2: With mode_i = 2'b11, every accepted edge of either phase moves the count by one. When phase A rises while B is low, the count goes up; the reverse sequence counts down.
- R3: With mode_i = 2'b01, only edges of phase B are counted. The step is up when the new B level equals the A level, and down otherwise.
- R4: With mode_i = 2'b10, only edges of phase A are counted. The step is up when the new A level differs from the B level, and down otherwise.
- R5: With mode_i = 2'b00, no edge changes count_o or dir_o.
- R6: inv_a_i and inv_b_i invert their phase after the filter. Setting exactly one of them reverses the counting direction for the same input motion. The polarity is to be changed only while mode_i is 2'b00.
- R7: A phase level change is accepted only after FILT_N consecutive synchronised samples at the new level. A pulse shorter than FILT_N cycles does not change the count.
- R8: A phase change applied before rising edge k shows on count_o after rising edge k+FILT_N+2, and not earlier.
- R9: An up step from a count at or above reload_i gives 0. A down step from 0 gives reload_i.
- R10: dir_o becomes 1 on a counted down step and 0 on a counted up step, and otherwise holds its value.
- R11: While count_en_i is 0, count_o and dir_o hold. Edges seen during that time are lost and are not applied after count_en_i returns to 1.
- R12: If both phases change in the same cycle, that transition is invalid and is not counted in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |
| count_en_i | input | 1 | Count enable; 0 freezes count and direction |
| mode_i | input | 2 | 00 off, 01 B edges, 10 A edges, 11 both phases |
| inv_a_i | input | 1 | Invert phase A |
| inv_b_i | input | 1 | Invert phase B |
| reload_i | input | CNT_W | Top of the count range |
| count_o | output | CNT_W | Position count |
| dir_o | output | 1 | 1 when the last counted step was down |

## Verification
The bench targets the wrap points in both directions. A design that gets these wrong would run past reload_i or land on the wrong value after underflow. It sends glitches one cycle shorter than the filter length, which a weak filter would count, and it checks the exact cycle on which a step appears. It also sends a simultaneous change of both phases, which a naive ×4 decoder would count as a step. Finally, it feeds edges while the count is disabled, where a design that latched pending steps would jump once the count is enabled again.

// File: rtl/qe_pkg.sv
package qe_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_B   = 2'b01,
    MODE_A   = 2'b10,
    MODE_AB  = 2'b11
  } qe_mode_e;
endpackage

// File: rtl/qe_sync_filter.sv
module qe_sync_filter #(
  parameter int FILT_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int CW = $clog2(FILT_N + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_N - 1);

  logic       s1_q, s2_q;
  logic [CW-1:0] run_q;
  logic       lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  // run length of samples that disagree with the accepted level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (s2_q != lvl_q) begin
      if (run_q == LAST) begin
        lvl_q <= s2_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/qe_decoder.sv
module qe_decoder
  import qe_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     a_i,
  input  logic     b_i,
  input  qe_mode_e mode_i,
  output logic     step_o,
  output logic     down_o
);
  logic a_q, b_q;
  logic a_edge, b_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign a_edge = a_i ^ a_q;
  assign b_edge = b_i ^ b_q;

  always_comb begin
    step_o = 1'b0;
    down_o = 1'b0;
    unique case (mode_i)
      MODE_B: begin
        step_o = b_edge & ~a_edge;
        down_o = (b_i != a_i);
      end
      MODE_A: begin
        step_o = a_edge & ~b_edge;
        down_o = (a_i == b_i);
      end
      MODE_AB: begin
        step_o = a_edge ^ b_edge;
        down_o = a_edge ? (a_i == b_i) : (b_i != a_i);
      end
      default: begin
        step_o = 1'b0;
        down_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/qe_counter.sv
module qe_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q;

  always_comb begin
    if (down_i) cnt_d = (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
    else        cnt_d = (cnt_q >= reload_i) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (en_i && step_i) begin
      cnt_q <= cnt_d;
      dir_q <= down_i;
    end
  end

  assign count_o = cnt_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/quad_enc_counter.sv
module quad_enc_counter
  import qe_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_a_i,
  input  logic             phase_b_i,
  input  logic             count_en_i,
  input  logic [1:0]       mode_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o
);
  localparam int NPH = 2;

  logic [NPH-1:0] raw, inv, lvl;
  logic           step, down;

  assign raw = {phase_b_i, phase_a_i};
  assign inv = {inv_b_i, inv_a_i};

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    logic flt;
    qe_sync_filter #(.FILT_N(FILT_N)) i_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .lvl_o (flt)
    );
    assign lvl[g] = flt ^ inv[g];
  end

  qe_decoder i_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (lvl[0]),
    .b_i   (lvl[1]),
    .mode_i(qe_mode_e'(mode_i)),
    .step_o(step),
    .down_o(down)
  );

  qe_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (count_en_i),
    .step_i  (step),
    .down_i  (down),
    .reload_i(reload_i),
    .count_o (count_o),
    .dir_o   (dir_o)
  );
endmodule

// File: rtl/qe_checker.sv
module qe_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             count_en_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] reload_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_o
);
  a_r2_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |->
      (count_o == CNT_W'($past(count_o) + 1'b1) || count_o == CNT_W'($past(count_o) - 1'b1)
       || count_o == '0 || count_o == $past(reload_i)));

  a_r5_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> ($stable(count_o) && $stable(dir_o)));

  a_r11_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en_i |=> ($stable(count_o) && $stable(dir_o)));

  a_r9_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_o && count_o != $past(count_o) && $past(count_o) >= $past(reload_i)) |-> (count_o == '0));

  a_r10_up_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CNT_W'($past(count_o) + 1'b1) && $past(count_o) != '0 && $past(count_o) < $past(reload_i))
      |-> !dir_o);
endmodule

bind quad_enc_counter qe_checker #(.CNT_W(CNT_W)) i_qe_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .count_en_i(count_en_i),
  .mode_i    (mode_i),
  .reload_i  (reload_i),
  .count_o   (count_o),
  .dir_o     (dir_o)
);

// File: tb/test_quad_enc_counter.sv
`timescale 1ns/1ps
module test_quad_enc_counter;
  localparam int CNT_W  = 16;
  localparam int FILT_N = 4;
  localparam int HOLD   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa = 0, pb = 0, en = 1, inva = 0, invb = 0;
  logic [1:0] mode = 2'b00;
  logic [CNT_W-1:0] reload = 16'd100;
  logic [CNT_W-1:0] count;
  logic dir;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  quad_enc_counter #(.CNT_W(CNT_W), .FILT_N(FILT_N)) i_quad_enc_counter (
    .clk_i(clk), .rst_ni(rst_n), .phase_a_i(pa), .phase_b_i(pb),
    .count_en_i(en), .mode_i(mode), .inv_a_i(inva), .inv_b_i(invb),
    .reload_i(reload), .count_o(count), .dir_o(dir)
  );

  // behavioural reference
  bit s1a, s2a, s1b, s2b, fa, fb, la_p, lb_p;
  int ra, rb;
  int m_cnt;
  bit m_dir;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1a = 0; s2a = 0; s1b = 0; s2b = 0; fa = 0; fb = 0; la_p = 0; lb_p = 0;
      ra = 0; rb = 0; m_cnt = 0; m_dir = 0;
    end else begin
      bit la, lb, ea, eb, cnt_it, dn;
      la = fa ^ inva; lb = fb ^ invb;
      ea = la != la_p; eb = lb != lb_p;
      cnt_it = 0; dn = 0;
      if (ea && eb) cnt_it = 0;
      else if (eb && (mode == 2'b01 || mode == 2'b11)) begin cnt_it = 1; dn = (lb != la); end
      else if (ea && (mode == 2'b10 || mode == 2'b11)) begin cnt_it = 1; dn = (la == lb); end
      if (cnt_it && en) begin
        m_dir = dn;
        if (dn) m_cnt = (m_cnt == 0) ? int'(reload) : m_cnt - 1;
        else    m_cnt = (m_cnt >= int'(reload)) ? 0 : m_cnt + 1;
      end
      la_p = la; lb_p = lb;
      if (s2a != fa) begin ra++; if (ra == FILT_N) begin fa = s2a; ra = 0; end end else ra = 0;
      if (s2b != fb) begin rb++; if (rb == FILT_N) begin fb = s2b; rb = 0; end end else rb = 0;
      s2a = s1a; s1a = pa;
      s2b = s1b; s1b = pb;
    end
  end

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check({tag, " count vs model"}, int'(count), m_cnt);
    check({tag, " dir vs model"}, int'(dir), int'(m_dir));
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fwd(int n);
    for (int i = 0; i < n; i++) begin
      if (pa == pb) pa = ~pa; else pb = ~pb;
      wait_n(HOLD);
    end
  endtask

  task automatic back(int n);
    for (int i = 0; i < n; i++) begin
      if (pa == pb) pb = ~pb; else pa = ~pa;
      wait_n(HOLD);
    end
  endtask

  initial begin
    int base;
    wait_n(3);
    check("R1 count after reset", int'(count), 0);
    check("R1 dir after reset", int'(dir), 0);
    rst_n = 1;
    wait_n(2);
    check("R1 count idle", int'(count), 0);

    tag = "R2"; mode = 2'b11;
    fwd(8);
    check("R2 x4 forward", int'(count), 8);
    check("R10 dir up", int'(dir), 0);
    back(4);
    check("R2 x4 backward", int'(count), 4);
    check("R10 dir down", int'(dir), 1);

    tag = "R3"; mode = 2'b01;
    fwd(8);
    check("R3 B-edge x2", int'(count), 8);
    back(4);
    check("R3 B-edge back", int'(count), 6);

    tag = "R4"; mode = 2'b10;
    fwd(8);
    check("R4 A-edge x2", int'(count), 10);

    tag = "R5"; mode = 2'b00;
    fwd(4);
    check("R5 off mode", int'(count), 10);

    tag = "R6"; inva = 1; wait_n(2); mode = 2'b11;
    fwd(4);
    check("R6 inverted A reverses", int'(count), 6);
    check("R6 dir down", int'(dir), 1);
    mode = 2'b00; wait_n(2); inva = 0; invb = 1; wait_n(2); mode = 2'b11;
    fwd(2);
    check("R6 inverted B reverses", int'(count), 4);
    mode = 2'b00; wait_n(2); invb = 0; wait_n(2); mode = 2'b11;

    tag = "R7"; base = int'(count);
    pa = ~pa; wait_n(FILT_N - 1); pa = ~pa; wait_n(HOLD);
    check("R7 short glitch ignored", int'(count), base);
    pb = ~pb; wait_n(1); pb = ~pb; wait_n(HOLD);
    check("R7 one-cycle glitch ignored", int'(count), base);

    tag = "R8"; base = int'(count);
    if (pa == pb) pa = ~pa; else pb = ~pb;
    wait_n(FILT_N + 2);
    check("R8 no change before latency", int'(count), base);
    wait_n(1);
    check("R8 change at latency", int'(count), base + 1);
    wait_n(HOLD);

    tag = "R9"; reload = count + 16'd1; wait_n(1);
    fwd(2);
    check("R9 up wrap to 0", int'(count), 0);
    back(1);
    check("R9 down wrap to reload", int'(count), int'(reload));
    check("R10 dir after down wrap", int'(dir), 1);
    fwd(1);
    check("R9 up wrap from reload", int'(count), 0);
    reload = 16'd100;

    tag = "R11"; base = int'(count);
    en = 0;
    back(3);
    check("R11 frozen count", int'(count), base);
    check("R11 frozen dir", int'(dir), 0);
    en = 1; wait_n(HOLD);
    check("R11 edges lost", int'(count), base);

    tag = "R12"; base = int'(count);
    pa = ~pa; pb = ~pb; wait_n(HOLD);
    check("R12 double change ignored", int'(count), base);
    fwd(3);
    check("R12 counting resumes", int'(count), base + 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule